// File: doc/BRIEF.md
# Two-Socket Indexed Control Register Bank

This block holds the control and status registers of a two-socket host adapter and makes them reachable through a pair of I/O ports. Software first writes a register number to the index port. It then reads or writes the selected register through the data port. Some registers exist once for the whole chip. Others exist once per socket. The second socket's copy of a per-socket register sits a fixed stride of 40h above the first socket's copy. The chip-wide registers show up inside every socket's window and always resolve to the same single copy.

Every bit of every register has a behaviour class:
- **Constant:** fixed, and never changed by writes.
- **Reserved:** holds its reset value, and writes are ignored.
- **Plain storage:** read/write. This covers scratchpad bits and compatibility-only bits.
- **Sticky event flag:** set by a hardware pulse and cleared when software writes a one to it.
- **Power-management context:** read/write storage that can survive a software reset.

The hardware reset initialises everything. The software bus-segment reset initialises everything except the context bits, and only when it arrives while the device is leaving the D3 power state with PME enabled. In every other case it initialises the context bits too. All register contents are also exported to the rest of the chip.

Top module: `srb_bank`

## Requirements
- R1: After the hardware reset, the index is 00h and reads return the following values.

  | Index | Value |
  |---|---|
  | 00h | 20h |
  | 01h | 00h |
  | 02h | 00h |
  | 03h | 60h |
  | 20h | A5h |
  | 21h | 00h |
  | 40h | 20h |
  | 41h | 00h |
  | 42h | 00h |
  | 43h | 60h |
  | 60h | A5h |
  | 61h | 00h |

- R2: Writes to the index port (`idx_wr`, with the index in `wdata`) take effect at the next rising edge. `rdata` follows the stored index combinationally, so it does not change before that edge.
- R3: Per-socket registers sit at offsets 00h–03h. Socket B's copy is at the Socket A index plus 40h. The two copies have independent storage, so a write or event in one socket leaves the other unchanged.
- R4: The chip-wide registers have one copy each, reached at 20h/21h and also at 60h/61h. A write through either index is read back through both.
- R5: Reading any index not listed in R1 returns 00h. A data write to such an index changes no register.
- R6: Constant bits ignore writes. These are the chip identifier at 20h (A5h), bits [5:4] of the status registers (value 10b), and bits [7:4] of the registers at 03h/43h (value 6h).
- R7: Plain storage bits load `wdata` on a data write. These are registers 01h/41h, bits [3:0] of 03h/43h, and bits [3:0] of 21h.
- R8: Status bits [3:0] at 00h/40h are sticky. They are set by `evt_i`: bits [3:0] go to Socket A and bits [7:4] to Socket B. Writing 1 to a sticky bit clears it, and writing 0 leaves it alone. When a set pulse and a clearing write hit the same bit in the same cycle, the bit ends up set.
- R9: Status bits [7:6] are reserved. They read 0 and writes are ignored.
- R10: A software reset (`sw_seg_rst` high at an edge) does three things:
  - It returns every non-context bit to its R1 value.
  - It clears the sticky bits.
  - It returns the index to 00h.

  The reset takes priority over a data write or an event in the same cycle.
- R11: Context bits are all of 02h/42h and bits [7:4] of 21h. They keep their value through a software reset when `pme_en` is 1 and `pwr_state` is 2'b11 (D3; 2'b00 is D0). In every other case a software reset returns them to 0.
- R12: The hardware reset initialises the context bits as well, whatever the values of `pme_en` and `pwr_state`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous hardware reset, active low |
| sw_seg_rst | input | 1 | Software bus-segment reset, synchronous, active high |
| pwr_state | input | 2 | Power state being left; 2'b11 is D3 |
| pme_en | input | 1 | PME enable |
| idx_wr | input | 1 | Index port write strobe |
| data_wr | input | 1 | Data port write strobe |
| wdata | input | 8 | Write data for index and data ports |
| evt_i | input | 8 | Sticky set pulses; [3:0] Socket A, [7:4] Socket B |
| rdata | output | 8 | Read data of the register at the stored index |
| sock_regs_o | output | 64 | Per-socket registers; socket s, offset r at bits [(s*4+r)*8 +: 8] |
| chip_regs_o | output | 16 | Chip-wide registers; register c at bits [c*8 +: 8] |

## Verification
Two kinds of result have different timing:
- **`rdata`:** combinational from the stored index. It is due in the same cycle as the rising edge that loads the index.
- **Register contents:** data writes, event pulses and both resets change them one rising edge after the stimulus is presented.

The driver presents every stimulus at a falling edge and releases it at the next falling edge. After releasing it, the driver hands the expected read value to the scoreboard. That falling edge sits half a cycle after the committing edge, so both the new index and the new register value are settled when compared. For the index-latency check, the value is sampled once before the loading edge, where the old value must still show, and again after it.

// File: rtl/srb_pkg.sv
`timescale 1ns/1ps
package srb_pkg;

   localparam int unsigned RB_DW = 8;

   typedef struct packed {
      logic [7:0] sticky;
      logic [7:0] konst;
      logic [7:0] rsvd;
      logic [7:0] ctx;
      logic [7:0] rstv;
   } reg_layout_t;

   // Bit classes of the per-socket registers, by offset.
   function automatic reg_layout_t sock_layout(input int unsigned r);
      reg_layout_t l;
      l = '0;
      case (r)
         0: begin
            l.sticky = 8'h0F;
            l.konst  = 8'h30;
            l.rsvd   = 8'hC0;
            l.rstv   = 8'h20;
         end
         1: l.rstv = 8'h00;
         2: l.ctx  = 8'hFF;
         3: begin
            l.konst = 8'hF0;
            l.rstv  = 8'h60;
         end
         default: begin
            l.konst = 8'hFF;
            l.rstv  = 8'h00;
         end
      endcase
      return l;
   endfunction

   // Bit classes of the chip-wide registers, by offset.
   function automatic reg_layout_t chip_layout(input int unsigned c);
      reg_layout_t l;
      l = '0;
      case (c)
         0: begin
            l.konst = 8'hFF;
            l.rstv  = 8'hA5;
         end
         1: l.ctx = 8'hF0;
         default: begin
            l.konst = 8'hFF;
            l.rstv  = 8'h00;
         end
      endcase
      return l;
   endfunction

endpackage

// File: rtl/srb_rst_sel.sv
`timescale 1ns/1ps
module srb_rst_sel #(
   parameter int unsigned   PSW     = 2,
   parameter logic [PSW-1:0] D3_CODE = '1
) (
   input  logic           sw_seg_rst,
   input  logic [PSW-1:0] pwr_state,
   input  logic           pme_en,
   output logic           init_base,
   output logic           init_ctx
);

   logic keep_ctx;

   always_comb begin
      keep_ctx  = pme_en && (pwr_state == D3_CODE);
      init_base = sw_seg_rst;
      init_ctx  = sw_seg_rst && !keep_ctx;
   end

endmodule

// File: rtl/srb_index.sv
`timescale 1ns/1ps
module srb_index #(
   parameter int unsigned IW = 8,
   parameter int unsigned DW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          init,
   input  logic          idx_wr,
   input  logic [DW-1:0] wdata,
   output logic [IW-1:0] ix
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ix <= '0;
      end else if (init) begin
         ix <= '0;
      end else if (idx_wr) begin
         ix <= IW'(wdata);
      end
   end

endmodule

// File: rtl/srb_reg.sv
`timescale 1ns/1ps
module srb_reg #(
   parameter int unsigned   DW       = 8,
   parameter logic [DW-1:0] STICKY_M = '0,
   parameter logic [DW-1:0] KONST_M  = '0,
   parameter logic [DW-1:0] RSVD_M   = '0,
   parameter logic [DW-1:0] CTX_M    = '0,
   parameter logic [DW-1:0] RSTV     = '0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          init_base,
   input  logic          init_ctx,
   input  logic          wr_en,
   input  logic [DW-1:0] wdata,
   input  logic [DW-1:0] set_evt,
   output logic [DW-1:0] q
);

   if ((STICKY_M & KONST_M) != '0 || (STICKY_M & RSVD_M) != '0 ||
       (STICKY_M & CTX_M) != '0 || (KONST_M & RSVD_M) != '0 ||
       (KONST_M & CTX_M) != '0 || (RSVD_M & CTX_M) != '0) begin : g_bad_masks
      $error("srb_reg: bit class masks overlap");
   end

   logic unused_sink;
   assign unused_sink = ^{clk, rst_n, init_base, init_ctx, wr_en, wdata, set_evt};

   for (genvar b = 0; b < DW; b++) begin : g_bit
      if (KONST_M[b]) begin : g_const
         assign q[b] = RSTV[b];
      end else if (RSVD_M[b]) begin : g_rsvd
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)         q[b] <= RSTV[b];
            else if (init_base) q[b] <= RSTV[b];
         end
      end else if (STICKY_M[b]) begin : g_sticky
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                   q[b] <= RSTV[b];
            else if (init_base)           q[b] <= RSTV[b];
            else if (set_evt[b])          q[b] <= 1'b1;
            else if (wr_en && wdata[b])   q[b] <= 1'b0;
         end
      end else if (CTX_M[b]) begin : g_ctx
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)        q[b] <= RSTV[b];
            else if (init_ctx) q[b] <= RSTV[b];
            else if (wr_en)    q[b] <= wdata[b];
         end
      end else begin : g_store
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)         q[b] <= RSTV[b];
            else if (init_base) q[b] <= RSTV[b];
            else if (wr_en)     q[b] <= wdata[b];
         end
      end
   end

endmodule

// File: rtl/srb_decode.sv
`timescale 1ns/1ps
module srb_decode #(
   parameter int unsigned DW        = 8,
   parameter int unsigned IW        = 8,
   parameter int unsigned NSOCK     = 2,
   parameter int unsigned NSR       = 4,
   parameter int unsigned NCR       = 2,
   parameter int unsigned STRIDE    = 64,
   parameter int unsigned CHIP_BASE = 32,
   localparam int unsigned NSW      = NSOCK * NSR
) (
   input  logic [IW-1:0]       ix,
   input  logic                data_wr,
   input  logic [NSW*DW-1:0]   sock_q,
   input  logic [NCR*DW-1:0]   chip_q,
   output logic [NSW-1:0]      sock_we,
   output logic [NCR-1:0]      chip_we,
   output logic [DW-1:0]       rdata
);

   always_comb begin
      rdata   = '0;
      sock_we = '0;
      chip_we = '0;
      for (int s = 0; s < NSOCK; s++) begin
         for (int r = 0; r < NSR; r++) begin
            if (ix == IW'(s * STRIDE + r)) begin
               sock_we[s*NSR+r] = data_wr;
               rdata            = sock_q[(s*NSR+r)*DW +: DW];
            end
         end
         for (int c = 0; c < NCR; c++) begin
            if (ix == IW'(s * STRIDE + CHIP_BASE + c)) begin
               chip_we[c] = chip_we[c] | data_wr;
               rdata      = chip_q[c*DW +: DW];
            end
         end
      end
   end

endmodule

// File: rtl/srb_bank.sv
`timescale 1ns/1ps
module srb_bank #(
   parameter int unsigned    DW        = 8,
   parameter int unsigned    IW        = 8,
   parameter int unsigned    NSOCK     = 2,
   parameter int unsigned    NSR       = 4,
   parameter int unsigned    NCR       = 2,
   parameter int unsigned    NEVT      = 4,
   parameter int unsigned    STRIDE    = 64,
   parameter int unsigned    CHIP_BASE = 32,
   parameter int unsigned    PSW       = 2,
   parameter logic [PSW-1:0] D3_CODE   = 2'b11
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    sw_seg_rst,
   input  logic [PSW-1:0]          pwr_state,
   input  logic                    pme_en,
   input  logic                    idx_wr,
   input  logic                    data_wr,
   input  logic [DW-1:0]           wdata,
   input  logic [NSOCK*NEVT-1:0]   evt_i,
   output logic [DW-1:0]           rdata,
   output logic [NSOCK*NSR*DW-1:0] sock_regs_o,
   output logic [NCR*DW-1:0]       chip_regs_o
);

   import srb_pkg::*;

   localparam int unsigned NSW      = NSOCK * NSR;
   localparam logic [7:0]  EVT_MASK = 8'((1 << NEVT) - 1);

   if (DW != RB_DW) begin : g_chk_dw
      $error("srb_bank: DW must match the register layout width");
   end
   if (CHIP_BASE < NSR || CHIP_BASE + NCR > STRIDE) begin : g_chk_map
      $error("srb_bank: chip-wide window overlaps a socket window");
   end
   if (NSOCK * STRIDE > (1 << IW)) begin : g_chk_iw
      $error("srb_bank: socket windows exceed the index range");
   end
   if (NEVT > DW || sock_layout(0).sticky != EVT_MASK) begin : g_chk_evt
      $error("srb_bank: event count does not match the status sticky field");
   end

   logic          init_base;
   logic          init_ctx;
   logic [IW-1:0] ix;
   logic [NSW-1:0] sock_we;
   logic [NCR-1:0] chip_we;

   srb_rst_sel #(.PSW(PSW), .D3_CODE(D3_CODE)) u_rst_sel (
      .sw_seg_rst (sw_seg_rst),
      .pwr_state  (pwr_state),
      .pme_en     (pme_en),
      .init_base  (init_base),
      .init_ctx   (init_ctx)
   );

   srb_index #(.IW(IW), .DW(DW)) u_index (
      .clk    (clk),
      .rst_n  (rst_n),
      .init   (init_base),
      .idx_wr (idx_wr),
      .wdata  (wdata),
      .ix     (ix)
   );

   for (genvar s = 0; s < NSOCK; s++) begin : g_sock
      for (genvar r = 0; r < NSR; r++) begin : g_reg
         localparam reg_layout_t L = sock_layout(r);
         logic [DW-1:0] evt_vec;
         if (r == 0) begin : g_evt
            assign evt_vec = DW'(evt_i[s*NEVT +: NEVT]);
         end else begin : g_noevt
            assign evt_vec = '0;
         end
         srb_reg #(
            .DW(DW), .STICKY_M(L.sticky), .KONST_M(L.konst),
            .RSVD_M(L.rsvd), .CTX_M(L.ctx), .RSTV(L.rstv)
         ) u_reg (
            .clk       (clk),
            .rst_n     (rst_n),
            .init_base (init_base),
            .init_ctx  (init_ctx),
            .wr_en     (sock_we[s*NSR+r]),
            .wdata     (wdata),
            .set_evt   (evt_vec),
            .q         (sock_regs_o[(s*NSR+r)*DW +: DW])
         );
      end
   end

   for (genvar c = 0; c < NCR; c++) begin : g_chip
      localparam reg_layout_t L = chip_layout(c);
      srb_reg #(
         .DW(DW), .STICKY_M(L.sticky), .KONST_M(L.konst),
         .RSVD_M(L.rsvd), .CTX_M(L.ctx), .RSTV(L.rstv)
      ) u_reg (
         .clk       (clk),
         .rst_n     (rst_n),
         .init_base (init_base),
         .init_ctx  (init_ctx),
         .wr_en     (chip_we[c]),
         .wdata     (wdata),
         .set_evt   ('0),
         .q         (chip_regs_o[c*DW +: DW])
      );
   end

   srb_decode #(
      .DW(DW), .IW(IW), .NSOCK(NSOCK), .NSR(NSR), .NCR(NCR),
      .STRIDE(STRIDE), .CHIP_BASE(CHIP_BASE)
   ) u_decode (
      .ix      (ix),
      .data_wr (data_wr),
      .sock_q  (sock_regs_o),
      .chip_q  (chip_regs_o),
      .sock_we (sock_we),
      .chip_we (chip_we),
      .rdata   (rdata)
   );

endmodule

// File: rtl/srb_bank_chk.sv
`timescale 1ns/1ps
module srb_bank_chk #(
   parameter int unsigned    DW        = 8,
   parameter int unsigned    IW        = 8,
   parameter int unsigned    NSOCK     = 2,
   parameter int unsigned    NSR       = 4,
   parameter int unsigned    NCR       = 2,
   parameter int unsigned    NEVT      = 4,
   parameter int unsigned    STRIDE    = 64,
   parameter int unsigned    CHIP_BASE = 32,
   parameter int unsigned    PSW       = 2,
   parameter logic [PSW-1:0] D3_CODE   = 2'b11
) (
   input logic                    clk,
   input logic                    rst_n,
   input logic                    sw_seg_rst,
   input logic [PSW-1:0]          pwr_state,
   input logic                    pme_en,
   input logic                    idx_wr,
   input logic                    data_wr,
   input logic [DW-1:0]           wdata,
   input logic [NSOCK*NEVT-1:0]   evt_i,
   input logic [DW-1:0]           rdata,
   input logic [NSOCK*NSR*DW-1:0] sock_regs_o,
   input logic [NCR*DW-1:0]       chip_regs_o
);

   logic [IW-1:0] shadow_ix;
   logic          keep;
   logic          implemented;
   logic          unused_chk;

   assign unused_chk = ^{chip_regs_o, evt_i};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          shadow_ix <= '0;
      else if (sw_seg_rst) shadow_ix <= '0;
      else if (idx_wr)     shadow_ix <= IW'(wdata);
   end

   always_comb begin
      int unsigned sk;
      int unsigned of;
      sk = int'(shadow_ix) / STRIDE;
      of = int'(shadow_ix) % STRIDE;
      implemented = (sk < NSOCK) &&
                    ((of < NSR) || (of >= CHIP_BASE && of < CHIP_BASE + NCR));
      keep = pme_en && (pwr_state == D3_CODE);
   end

   AST_UNIMPL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      !implemented |-> rdata == '0); // R5

   AST_STICKY_SET: assert property (@(posedge clk) disable iff (!rst_n)
      evt_i[0] && !sw_seg_rst |=> sock_regs_o[0]); // R8

   AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !evt_i[0] && !sw_seg_rst && !(data_wr && shadow_ix == '0 && wdata[0])
      |=> $stable(sock_regs_o[0])); // R8

   AST_SCRATCH_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      data_wr && shadow_ix == IW'(1) && !sw_seg_rst
      |=> sock_regs_o[DW +: DW] == $past(wdata)); // R7

   AST_CTX_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
      sw_seg_rst && keep && !data_wr |=> $stable(sock_regs_o[2*DW +: DW])); // R11

   AST_CTX_INIT: assert property (@(posedge clk) disable iff (!rst_n)
      sw_seg_rst && !keep |=> sock_regs_o[2*DW +: DW] == '0); // R11

endmodule

bind srb_bank srb_bank_chk #(
   .DW(DW), .IW(IW), .NSOCK(NSOCK), .NSR(NSR), .NCR(NCR), .NEVT(NEVT),
   .STRIDE(STRIDE), .CHIP_BASE(CHIP_BASE), .PSW(PSW), .D3_CODE(D3_CODE)
) u_chk (.*);

// File: tb/srb_bank_tb.sv
`timescale 1ns/1ps
module srb_bank_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        sw_seg_rst = 1'b0;
   logic [1:0]  pwr_state = 2'b00;
   logic        pme_en = 1'b0;
   logic        idx_wr = 1'b0;
   logic        data_wr = 1'b0;
   logic [7:0]  wdata = 8'h00;
   logic [7:0]  evt_i = 8'h00;
   logic [7:0]  rdata;
   logic [63:0] sock_regs_o;
   logic [15:0] chip_regs_o;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   logic [7:0] exp_q[$];
   string      tag_q[$];
   event       mon_ev;

   always #2.5 clk = ~clk;

   srb_bank u_dut (
      .clk(clk), .rst_n(rst_n), .sw_seg_rst(sw_seg_rst), .pwr_state(pwr_state),
      .pme_en(pme_en), .idx_wr(idx_wr), .data_wr(data_wr), .wdata(wdata),
      .evt_i(evt_i), .rdata(rdata), .sock_regs_o(sock_regs_o),
      .chip_regs_o(chip_regs_o)
   );

   task automatic chk(input logic [63:0] act, input logic [63:0] exp, input string tag);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // Monitor: pops expected items and compares against the read port.
   initial begin
      forever begin
         @(mon_ev);
         while (exp_q.size() > 0) begin
            logic [7:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            chk(64'(rdata), 64'(e), t);
         end
      end
   end

   task automatic set_ix(input logic [7:0] ix);
      @(negedge clk);
      idx_wr = 1'b1;
      wdata  = ix;
      @(negedge clk);
      idx_wr = 1'b0;
   endtask

   task automatic expect_rd(input logic [7:0] ix, input logic [7:0] e, input string tag);
      set_ix(ix);
      exp_q.push_back(e);
      tag_q.push_back(tag);
      -> mon_ev;
      #0.1;
   endtask

   task automatic wr_data(input logic [7:0] ix, input logic [7:0] v);
      set_ix(ix);
      data_wr = 1'b1;
      wdata   = v;
      @(negedge clk);
      data_wr = 1'b0;
   endtask

   task automatic pulse_evt(input logic [7:0] v);
      @(negedge clk);
      evt_i = v;
      @(negedge clk);
      evt_i = 8'h00;
   endtask

   task automatic sw_rst(input logic pme, input logic [1:0] pw);
      @(negedge clk);
      pme_en     = pme;
      pwr_state  = pw;
      sw_seg_rst = 1'b1;
      @(negedge clk);
      sw_seg_rst = 1'b0;
      pme_en     = 1'b0;
      pwr_state  = 2'b00;
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      failures++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      logic [63:0] snap_s;
      logic [15:0] snap_c;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset values
      chk(64'(rdata), 64'h20, "R1 index 00h after reset");
      expect_rd(8'h00, 8'h20, "R1 A status");
      expect_rd(8'h01, 8'h00, "R1 A ctrl");
      expect_rd(8'h02, 8'h00, "R1 A ctx");
      expect_rd(8'h03, 8'h60, "R1 A compat");
      expect_rd(8'h20, 8'hA5, "R1 chip id");
      expect_rd(8'h21, 8'h00, "R1 chip misc");
      expect_rd(8'h40, 8'h20, "R1 B status");
      expect_rd(8'h41, 8'h00, "R1 B ctrl");
      expect_rd(8'h42, 8'h00, "R1 B ctx");
      expect_rd(8'h43, 8'h60, "R1 B compat");
      expect_rd(8'h60, 8'hA5, "R1 chip id alias");
      expect_rd(8'h61, 8'h00, "R1 chip misc alias");

      // R7 / R3 storage, independent socket copies
      wr_data(8'h01, 8'h3C);
      wr_data(8'h41, 8'hC3);
      expect_rd(8'h01, 8'h3C, "R7 A ctrl write");
      expect_rd(8'h41, 8'hC3, "R3 B ctrl independent");

      // R6 constant fields, R7 compat storage
      wr_data(8'h03, 8'hFF);
      expect_rd(8'h03, 8'h6F, "R6 compat const upper with ones");
      wr_data(8'h03, 8'h00);
      expect_rd(8'h03, 8'h60, "R6 compat const upper with zeros");
      wr_data(8'h20, 8'h00);
      expect_rd(8'h20, 8'hA5, "R6 chip id write ignored");

      // R9 reserved bits, and sticky cleared stays clear
      wr_data(8'h00, 8'hFF);
      expect_rd(8'h00, 8'h20, "R9 status reserved ignore write");

      // R8 sticky
      pulse_evt(8'h05);
      expect_rd(8'h00, 8'h25, "R8 A sticky set");
      expect_rd(8'h40, 8'h20, "R3 B status untouched by A event");
      wr_data(8'h00, 8'h01);
      expect_rd(8'h00, 8'h24, "R8 write one clears");
      wr_data(8'h00, 8'h00);
      expect_rd(8'h00, 8'h24, "R8 write zero keeps");
      set_ix(8'h00);
      data_wr = 1'b1;
      wdata   = 8'h06;
      evt_i   = 8'h02;
      @(negedge clk);
      data_wr = 1'b0;
      evt_i   = 8'h00;
      expect_rd(8'h00, 8'h22, "R8 set wins over clear");
      pulse_evt(8'h80);
      expect_rd(8'h40, 8'h28, "R8 B sticky bit3");

      // R4 chip-wide single copy
      wr_data(8'h61, 8'h5A);
      expect_rd(8'h21, 8'h5A, "R4 chip misc via alias");

      // R5 unimplemented index
      expect_rd(8'h10, 8'h00, "R5 unimplemented read");
      snap_s = sock_regs_o;
      snap_c = chip_regs_o;
      wr_data(8'h10, 8'hFF);
      chk(sock_regs_o, snap_s, "R5 unimplemented write socket regs");
      chk(64'(chip_regs_o), 64'(snap_c), "R5 unimplemented write chip regs");
      expect_rd(8'h44, 8'h00, "R5 unimplemented socket B offset");

      // R11 context kept
      wr_data(8'h02, 8'h96);
      wr_data(8'h42, 8'h69);
      wr_data(8'h21, 8'hB7);
      sw_rst(1'b1, 2'b11);
      chk(64'(rdata), 64'h20, "R10 index back to 00h");
      expect_rd(8'h02, 8'h96, "R11 A ctx kept");
      expect_rd(8'h42, 8'h69, "R11 B ctx kept");
      expect_rd(8'h21, 8'hB0, "R11 chip ctx nibble kept");
      expect_rd(8'h01, 8'h00, "R10 A ctrl reset");
      expect_rd(8'h41, 8'h00, "R10 B ctrl reset");
      expect_rd(8'h00, 8'h20, "R10 A sticky cleared");
      expect_rd(8'h40, 8'h20, "R10 B sticky cleared");

      // R11 context reset when not kept
      sw_rst(1'b0, 2'b11);
      expect_rd(8'h02, 8'h00, "R11 ctx reset without pme");
      expect_rd(8'h61, 8'h00, "R11 chip ctx reset without pme");
      wr_data(8'h02, 8'h11);
      sw_rst(1'b1, 2'b00);
      expect_rd(8'h02, 8'h00, "R11 ctx reset when not from D3");

      // R10 reset beats write
      set_ix(8'h01);
      data_wr    = 1'b1;
      wdata      = 8'h77;
      sw_seg_rst = 1'b1;
      @(negedge clk);
      data_wr    = 1'b0;
      sw_seg_rst = 1'b0;
      expect_rd(8'h01, 8'h00, "R10 sw reset beats write");

      // R12 hardware reset clears context
      wr_data(8'h02, 8'h5C);
      wr_data(8'h21, 8'hF0);
      @(negedge clk);
      pme_en    = 1'b1;
      pwr_state = 2'b11;
      rst_n     = 1'b0;
      @(negedge clk);
      rst_n     = 1'b1;
      pme_en    = 1'b0;
      pwr_state = 2'b00;
      expect_rd(8'h02, 8'h00, "R12 hw reset clears A ctx");
      expect_rd(8'h21, 8'h00, "R12 hw reset clears chip ctx");

      // R2 index latency
      set_ix(8'h03);
      chk(64'(rdata), 64'h60, "R2 index loaded");
      @(negedge clk);
      idx_wr = 1'b1;
      wdata  = 8'h20;
      #1;
      chk(64'(rdata), 64'h60, "R2 old value before edge");
      @(negedge clk);
      idx_wr = 1'b0;
      chk(64'(rdata), 64'hA5, "R2 new value after edge");

      repeat (2) @(negedge clk);
      finish_run();
   end

endmodule